// File: doc/BRIEF.md
# Prescaled Match/Capture Timer

This block is a 16-bit timer peripheral reached over a small register bus with word-aligned offsets. A prescale counter divides the peripheral clock, and the main count advances each time the prescaler wraps. In counter mode the prescaler is bypassed. The count then advances on selected edges of a synchronized external input.

Four compare registers watch the count. Each compare has three optional actions: raise an interrupt flag, clear the count, and halt counting. Two capture inputs copy the count when a selected edge arrives on them. Two match pins either follow an edge-driven set/clear/toggle state or act as PWM outputs. A single interrupt line is the OR of all pending flags.

Top module: `prescaled_match_timer`

## Requirements
- R1: After reset every register reads zero, `irq` is 0 and `mat_out` is 0.
- R2: In timer mode with the control run bit (bit 0, offset 0x004) set, the prescale counter (0x010) counts 0..PR, where PR is at 0x00C. The count (0x008) increments once per PR+1 clocks, on the clock where the prescale counter wraps to 0.
- R3: While control bit 1 is set, the count and the prescale counter are held at zero. While bit 0 is clear, both keep their values.
- R4: Software writes to the count and to the prescale counter take effect on the next clock and read back.
- R5: Compare registers sit at 0x018, 0x01C, 0x020 and 0x024. The match control register (0x014) gives compare i three bits: bit 3i sets interrupt flag i when the count becomes equal to the compare value; bit 3i+1 makes the count go to 0 on the tick after it equals the compare value, giving a period of compare+1 ticks; bit 3i+2 halts the count at the compare value and clears control bit 0. A halt takes priority over a software write of the run bit in the same cycle.
- R6: The flag register (0x000) holds match flags 0..3 in bits 0..3 and the capture-0 flag in bit 4. Writing a 1 clears that flag, and a new event in the same cycle wins over the clear. `irq` is the OR of the flags.
- R7: Capture control (0x028) gives input j a rise-enable bit 3j and a fall-enable bit 3j+1. A selected edge on `cap_in[j]` copies the count into capture register j, read-only at 0x02C or 0x030, within three clocks. Edges that are not selected, and bus writes to these registers, have no effect.
- R8: Capture control bit 2 makes a capture-0 load set flag bit 4.
- R9: Mode register (0x070) bits [1:0] select the source: 00 is timer mode; 01, 10 and 11 count rising edges, falling edges or both edges. Bit 2 picks `cnt_in` (0) or `cap_in[1]` (1) as the counted input. In counter mode each qualifying edge adds exactly one and the prescale counter stays unchanged.
- R10: External match register (0x03C) bits [1:0] hold the state driven on `mat_out` when PWM is off. Bits [5:4] set the action on compare-0 events and bits [7:6] set the action on compare-1 events: 00 keep, 01 clear, 10 set, 11 toggle. The state bits can also be written directly.
- R11: PWM control (0x074) bit p makes `mat_out[p]` equal 1 exactly when the count is at or above compare p, and 0 below it.
- R12: Compare registers, prescale, external match, mode and PWM control all read back what was written at their offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 7 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cap_in | input | 2 | Capture inputs (asynchronous) |
| cnt_in | input | 1 | External count input (asynchronous) |
| irq | output | 1 | OR of pending interrupt flags |
| mat_out | output | 2 | Match/PWM outputs |

## Verification
Most internal faults show up as a count value read at the wrong cycle. A prescaler that wraps one step early or late shifts the count after 16 clocks by a whole tick. A missed compare-clear lets the count run past the compare value within one period. A lost halt leaves the run bit set. Capture and edge-detection faults show as a wrong capture value, or as a wrong count in counter mode, three clocks after the input edge. EMR and PWM faults are visible on `mat_out` directly, either at the next match event or with no delay after a count write.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

  // Word indices (byte offset / 4) of the register file.
  localparam int unsigned IDX_FLAGS  = 0;
  localparam int unsigned IDX_CTRL   = 1;
  localparam int unsigned IDX_COUNT  = 2;
  localparam int unsigned IDX_PRESC  = 3;
  localparam int unsigned IDX_PCOUNT = 4;
  localparam int unsigned IDX_MCTRL  = 5;
  localparam int unsigned IDX_CMP0   = 6;
  localparam int unsigned IDX_CCTRL  = 10;
  localparam int unsigned IDX_CAP0   = 11;
  localparam int unsigned IDX_EXTM   = 15;
  localparam int unsigned IDX_MODE   = 28;
  localparam int unsigned IDX_PWM    = 29;

  // Position of the first pin action field in the external match register.
  localparam int unsigned EXT_ACT_LSB = 4;

  typedef enum logic [1:0] {
    PIN_KEEP   = 2'b00,
    PIN_CLEAR  = 2'b01,
    PIN_SET    = 2'b10,
    PIN_TOGGLE = 2'b11
  } pin_act_e;

  // New pin state after a match event.
  function automatic logic pin_apply(input logic cur, input logic [1:0] act);
    case (pin_act_e'(act))
      PIN_CLEAR:  return 1'b0;
      PIN_SET:    return 1'b1;
      PIN_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

  // PWM level: high once the count has reached the compare value.
  function automatic logic pwm_level(input logic [31:0] cnt, input logic [31:0] cmp);
    return cnt >= cmp;
  endfunction

  // Prescaler wrap condition.
  function automatic logic presc_wrap(input logic [31:0] pc, input logic [31:0] pr);
    return pc == pr;
  endfunction

endpackage

// File: rtl/ptm_sync_edge.sv
module ptm_sync_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [2:0] sh_q;  // [0],[1] synchronizer, [2] previous synchronized value
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[1:0], din[g]};
    end
    assign rise[g] = sh_q[1] & ~sh_q[2];
    assign fall[g] = ~sh_q[1] & sh_q[2];
  end

endmodule

// File: rtl/ptm_count_core.sv
module ptm_count_core
  import ptm_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          hold,
  input  logic          cnt_mode,
  input  logic          ext_tick,
  input  logic          stop_req,
  input  logic          clr_req,
  input  logic          wr_tc,
  input  logic          wr_pc,
  input  logic [TW-1:0] wval,
  input  logic [TW-1:0] pr,
  output logic [TW-1:0] tc,
  output logic [TW-1:0] pc,
  output logic          adv
);

  logic          active;
  logic          wrap;
  logic [TW-1:0] tc_q, pc_q;

  assign active = run & ~hold & ~stop_req;
  assign wrap   = presc_wrap(32'(pc_q), 32'(pr));
  assign adv    = active & (cnt_mode ? ext_tick : wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      tc_q <= '0;
    end else if (hold) begin
      pc_q <= '0;
      tc_q <= '0;
    end else begin
      if (wr_pc)                     pc_q <= wval;
      else if (active && !cnt_mode)  pc_q <= wrap ? '0 : pc_q + TW'(1);

      if (wr_tc)     tc_q <= wval;
      else if (adv)  tc_q <= clr_req ? '0 : tc_q + TW'(1);
    end
  end

  assign tc = tc_q;
  assign pc = pc_q;

  // R2: the prescaler wraps to zero after reaching PR
  a_r2_presc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !hold && !stop_req && !cnt_mode && !wr_pc && pc_q == pr) |=> (pc_q == '0));

  // R2: the count only moves on an advance or a write
  a_r2_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !wr_tc && !adv) |=> $stable(tc_q));

  // R3: hold forces both counters to zero
  a_r3_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (tc_q == '0 && pc_q == '0));

endmodule

// File: rtl/ptm_match_unit.sv
module ptm_match_unit #(
  parameter int TW = 16,
  parameter int NM = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   armed,
  input  logic [TW-1:0]          tc,
  input  logic [NM-1:0][TW-1:0]  cmp,
  input  logic [3*NM-1:0]        mctl,
  output logic [NM-1:0]          evt,
  output logic [NM-1:0]          int_req,
  output logic                   stop_req,
  output logic                   clr_req
);

  logic [NM-1:0] level, level_q, stop_v, clr_v;

  for (genvar i = 0; i < NM; i++) begin : g_cmp
    assign level[i]   = armed & (tc == cmp[i]);
    assign evt[i]     = level[i] & ~level_q[i];
    assign int_req[i] = evt[i] & mctl[3*i];
    assign clr_v[i]   = (tc == cmp[i]) & mctl[3*i+1];
    assign stop_v[i]  = level[i] & mctl[3*i+2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level;
  end

  assign stop_req = |stop_v;
  assign clr_req  = |clr_v;

  // R5: a match event lasts a single cycle
  a_r5_evt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((evt & $past(evt)) == '0));

endmodule

// File: rtl/prescaled_match_timer.sv
module prescaled_match_timer
  import ptm_pkg::*;
#(
  parameter int TW   = 16,
  parameter int NM   = 4,
  parameter int NC   = 2,
  parameter int NPIN = 2,
  parameter int AW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NC-1:0]   cap_in,
  input  logic            cnt_in,
  output logic            irq,
  output logic [NPIN-1:0] mat_out
);

  localparam int FW  = NM + 1;                 // flag bits
  localparam int MCW = 3 * NM;                 // match control width
  localparam int CCW = 3 * NC;                 // capture control width
  localparam int EMW = EXT_ACT_LSB + 2 * NPIN; // external match width

  logic [FW-1:0]          flags_q;
  logic [1:0]             ctrl_q;
  logic [TW-1:0]          presc_q;
  logic [MCW-1:0]         mctl_q;
  logic [NM-1:0][TW-1:0]  cmp_q;
  logic [CCW-1:0]         cctl_q;
  logic [NC-1:0][TW-1:0]  cap_q;
  logic [EMW-1:0]         extm_q;
  logic [2:0]             mode_q;
  logic [NPIN-1:0]        pwm_q;

  logic [TW-1:0] tc, pc;
  logic          adv;
  logic [NM-1:0] m_evt, m_int;
  logic          stop_req, clr_req;
  logic [NC-1:0] cap_rise, cap_fall, cap_evt;
  logic          cnt_rise, cnt_fall, src_rise, src_fall, ext_tick;
  logic          cnt_mode;
  logic [FW-1:0] flag_set, flag_clr;
  logic [31:0]   widx;

  assign widx = 32'(bus_addr[AW-1:2]);

  function automatic logic wsel(input int unsigned idx);
    return bus_we && (widx == idx);
  endfunction

  // ---------------- edge front ends ----------------
  ptm_sync_edge #(.W(NC)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_in), .rise(cap_rise), .fall(cap_fall)
  );

  ptm_sync_edge #(.W(1)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .din(cnt_in), .rise(cnt_rise), .fall(cnt_fall)
  );

  assign src_rise = mode_q[2] ? cap_rise[NC-1] : cnt_rise;
  assign src_fall = mode_q[2] ? cap_fall[NC-1] : cnt_fall;
  assign ext_tick = (mode_q[0] & src_rise) | (mode_q[1] & src_fall);
  assign cnt_mode = |mode_q[1:0];

  // ---------------- counting ----------------
  ptm_count_core #(.TW(TW)) u_core (
    .clk(clk), .rst_n(rst_n),
    .run(ctrl_q[0]), .hold(ctrl_q[1]),
    .cnt_mode(cnt_mode), .ext_tick(ext_tick),
    .stop_req(stop_req), .clr_req(clr_req),
    .wr_tc(wsel(IDX_COUNT)), .wr_pc(wsel(IDX_PCOUNT)),
    .wval(bus_wdata[TW-1:0]), .pr(presc_q),
    .tc(tc), .pc(pc), .adv(adv)
  );

  ptm_match_unit #(.TW(TW), .NM(NM)) u_match (
    .clk(clk), .rst_n(rst_n),
    .armed(ctrl_q[0] & ~ctrl_q[1]),
    .tc(tc), .cmp(cmp_q), .mctl(mctl_q),
    .evt(m_evt), .int_req(m_int),
    .stop_req(stop_req), .clr_req(clr_req)
  );

  // ---------------- plain registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      mctl_q  <= '0;
      cctl_q  <= '0;
      mode_q  <= '0;
      pwm_q   <= '0;
    end else begin
      if (wsel(IDX_CTRL))  ctrl_q  <= bus_wdata[1:0];
      if (stop_req)        ctrl_q[0] <= 1'b0;   // halt wins over a write
      if (wsel(IDX_PRESC)) presc_q <= bus_wdata[TW-1:0];
      if (wsel(IDX_MCTRL)) mctl_q  <= bus_wdata[MCW-1:0];
      if (wsel(IDX_CCTRL)) cctl_q  <= bus_wdata[CCW-1:0];
      if (wsel(IDX_MODE))  mode_q  <= bus_wdata[2:0];
      if (wsel(IDX_PWM))   pwm_q   <= bus_wdata[NPIN-1:0];
    end
  end

  for (genvar i = 0; i < NM; i++) begin : g_cmp_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cmp_q[i] <= '0;
      else if (wsel(IDX_CMP0 + i))         cmp_q[i] <= bus_wdata[TW-1:0];
    end
  end

  // ---------------- capture ----------------
  for (genvar j = 0; j < NC; j++) begin : g_cap
    assign cap_evt[j] = (cap_rise[j] & cctl_q[3*j]) | (cap_fall[j] & cctl_q[3*j+1]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cap_q[j] <= '0;
      else if (cap_evt[j]) cap_q[j] <= tc;
    end

    // R7: a capture event stores the count seen in that cycle
    a_r7_cap_load: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[j] |=> (cap_q[j] == $past(tc)));
  end

  // ---------------- interrupt flags ----------------
  assign flag_set = {cap_evt[0] & cctl_q[2], m_int};
  assign flag_clr = wsel(IDX_FLAGS) ? bus_wdata[FW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  assign irq = |flags_q;

  // R6: a pending flag survives unless a one is written to it
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(flags_q & ~flag_clr)) == $past(flags_q & ~flag_clr)));

  // R5: a halting match drops the run bit
  a_r5_halt_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !ctrl_q[0]);

  // ---------------- external match pins ----------------
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    localparam int AL = EXT_ACT_LSB + 2 * p;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        extm_q[p]       <= 1'b0;
        extm_q[AL+1:AL] <= 2'b00;
      end else if (wsel(IDX_EXTM)) begin
        extm_q[p]       <= bus_wdata[p];
        extm_q[AL+1:AL] <= bus_wdata[AL+1:AL];
      end else if (m_evt[p]) begin
        extm_q[p]       <= pin_apply(extm_q[p], extm_q[AL+1:AL]);
      end
    end
    assign mat_out[p] = pwm_q[p] ? pwm_level(32'(tc), 32'(cmp_q[p])) : extm_q[p];
  end

  if (EXT_ACT_LSB > NPIN) begin : g_extm_pad
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) extm_q[EXT_ACT_LSB-1:NPIN] <= '0;
      else        extm_q[EXT_ACT_LSB-1:NPIN] <= '0;
    end
  end

  // ---------------- read path ----------------
  always_comb begin
    bus_rdata = '0;
    case (widx)
      IDX_FLAGS:  bus_rdata = 32'(flags_q);
      IDX_CTRL:   bus_rdata = 32'(ctrl_q);
      IDX_COUNT:  bus_rdata = 32'(tc);
      IDX_PRESC:  bus_rdata = 32'(presc_q);
      IDX_PCOUNT: bus_rdata = 32'(pc);
      IDX_MCTRL:  bus_rdata = 32'(mctl_q);
      IDX_CCTRL:  bus_rdata = 32'(cctl_q);
      IDX_EXTM:   bus_rdata = 32'(extm_q);
      IDX_MODE:   bus_rdata = 32'(mode_q);
      IDX_PWM:    bus_rdata = 32'(pwm_q);
      default: begin
        for (int i = 0; i < NM; i++)
          if (widx == IDX_CMP0 + i) bus_rdata = 32'(cmp_q[i]);
        for (int j = 0; j < NC; j++)
          if (widx == IDX_CAP0 + j) bus_rdata = 32'(cap_q[j]);
      end
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata, cctl_q, adv};

endmodule

// File: tb/prescaled_match_timer_tb.sv
module prescaled_match_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  cap_in = '0;
  logic        cnt_in = 1'b0;
  logic        irq;
  logic [1:0]  mat_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // register byte offsets
  localparam logic [6:0] A_FLG = 7'h00, A_CTL = 7'h04, A_TC = 7'h08, A_PR = 7'h0C,
                         A_PC = 7'h10, A_MCR = 7'h14, A_M0 = 7'h18, A_M1 = 7'h1C,
                         A_M2 = 7'h20, A_M3 = 7'h24, A_CCR = 7'h28, A_CR0 = 7'h2C,
                         A_CR1 = 7'h30, A_EXT = 7'h3C, A_MODE = 7'h70, A_PWM = 7'h74;

  always #2.5 clk = ~clk;

  prescaled_match_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .cnt_in(cnt_in), .irq(irq), .mat_out(mat_out)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic pulse_cnt(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); cnt_in = 1'b1;
      wait_edges(3);
      cnt_in = 1'b0;
      wait_edges(3);
    end
  endtask

  task automatic t_reset;
    rd_chk("R1 flags", A_FLG, 0);  rd_chk("R1 ctrl", A_CTL, 0);
    rd_chk("R1 count", A_TC, 0);   rd_chk("R1 presc", A_PR, 0);
    rd_chk("R1 pcount", A_PC, 0);  rd_chk("R1 mctl", A_MCR, 0);
    rd_chk("R1 cmp3", A_M3, 0);    rd_chk("R1 cap0", A_CR0, 0);
    rd_chk("R1 extm", A_EXT, 0);   rd_chk("R1 mode", A_MODE, 0);
    rd_chk("R1 pwm", A_PWM, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 mat_out", 32'(mat_out), 0);
  endtask

  task automatic t_prescale;
    wr(A_PR, 3);
    wr(A_CTL, 2);
    wr(A_CTL, 1);
    wait_edges(16);
    rd_chk("R2 count after 16 clocks", A_TC, 4);
    rd_chk("R2 pcount wrapped", A_PC, 0);
    wait_edges(2);
    rd_chk("R2 pcount mid", A_PC, 2);
    rd_chk("R2 count steady", A_TC, 4);
  endtask

  task automatic t_hold_and_write;
    wr(A_CTL, 3);
    wait_edges(5);
    rd_chk("R3 hold count", A_TC, 0);
    rd_chk("R3 hold pcount", A_PC, 0);
    wr(A_CTL, 0);
    wr(A_TC, 9);
    wr(A_PC, 2);
    wait_edges(8);
    rd_chk("R3 frozen count", A_TC, 9);
    rd_chk("R4 pcount written", A_PC, 2);
  endtask

  task automatic t_match_reset_int;
    logic [31:0] v;
    wr(A_CTL, 2);
    wr(A_PR, 0);
    wr(A_M0, 5);
    wr(A_MCR, 3);
    wr(A_FLG, 32'h1f);
    wr(A_CTL, 1);
    wait_edges(5);
    rd_chk("R5 count at compare", A_TC, 5);
    wait_edges(1);
    rd_chk("R5 count cleared on match", A_TC, 0);
    wait_edges(20);
    wr(A_CTL, 0);
    rd(A_TC, v);
    chk("R5 count never passes compare", 32'(v <= 5), 1);
    rd_chk("R5 match0 flag", A_FLG, 1);
    chk("R6 irq pending", 32'(irq), 1);
    wr(A_FLG, 1);
    rd_chk("R6 flag cleared", A_FLG, 0);
    chk("R6 irq idle", 32'(irq), 0);
  endtask

  task automatic t_match_stop;
    wr(A_CTL, 2);
    wr(A_MCR, 32'h20);
    wr(A_M1, 7);
    wr(A_CTL, 1);
    wait_edges(20);
    rd_chk("R5 halted at compare", A_TC, 7);
    rd_chk("R5 run bit cleared", A_CTL, 0);
    rd_chk("R5 pcount halted", A_PC, 0);
    wr(A_MCR, 0);
  endtask

  task automatic t_capture;
    wr(A_CTL, 0);
    wr(A_TC, 32'h1234);
    wr(A_CCR, 32'h05);
    wr(A_FLG, 32'h1f);
    @(negedge clk); cap_in[0] = 1'b1;
    wait_edges(4);
    rd_chk("R7 cap0 on rise", A_CR0, 32'h1234);
    rd_chk("R8 capture flag", A_FLG, 32'h10);
    wr(A_TC, 32'h55);
    @(negedge clk); cap_in[0] = 1'b0;
    wait_edges(4);
    rd_chk("R7 unselected fall ignored", A_CR0, 32'h1234);
    wr(A_CR0, 32'hAAAA);
    rd_chk("R7 capture read-only", A_CR0, 32'h1234);
    wr(A_FLG, 32'h1f);
    wr(A_CCR, 32'h10);
    wr(A_TC, 32'h77);
    @(negedge clk); cap_in[1] = 1'b1;
    wait_edges(4);
    rd_chk("R7 cap1 rise ignored", A_CR1, 0);
    @(negedge clk); cap_in[1] = 1'b0;
    wait_edges(4);
    rd_chk("R7 cap1 on fall", A_CR1, 32'h77);
    rd_chk("R8 no flag without enable", A_FLG, 0);
    wr(A_CCR, 0);
  endtask

  task automatic t_counter;
    wr(A_CTL, 2);
    wr(A_PR, 5);
    wr(A_MODE, 1);
    wr(A_CTL, 1);
    pulse_cnt(3);
    wait_edges(4);
    rd_chk("R9 rising edges counted", A_TC, 3);
    rd_chk("R9 prescaler bypassed", A_PC, 0);
    wr(A_MODE, 3);
    wr(A_TC, 0);
    pulse_cnt(2);
    wait_edges(4);
    rd_chk("R9 both edges counted", A_TC, 4);
    wr(A_MODE, 2);
    wr(A_TC, 0);
    pulse_cnt(1);
    wait_edges(4);
    rd_chk("R9 falling edge counted", A_TC, 1);
    wr(A_MODE, 5);
    wr(A_TC, 0);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); cap_in[1] = 1'b1;
      wait_edges(3);
      cap_in[1] = 1'b0;
      wait_edges(3);
    end
    pulse_cnt(1);
    wait_edges(4);
    rd_chk("R9 alternate input selected", A_TC, 2);
    wr(A_CTL, 0);
    wr(A_MODE, 0);
    wr(A_PR, 0);
  endtask

  task automatic t_extmatch;
    wr(A_EXT, 32'h02);
    chk("R10 direct pin state", 32'(mat_out), 2);
    rd_chk("R10 state readback", A_EXT, 2);
    wr(A_EXT, 32'h20);
    chk("R10 state rewritten", 32'(mat_out), 0);
    wr(A_M0, 3);
    wr(A_MCR, 32'h2);
    wr(A_CTL, 2);
    wr(A_CTL, 1);
    wait_edges(10);
    chk("R10 set action", 32'(mat_out[0]), 1);
    rd_chk("R10 set action readback", A_EXT, 32'h21);
    wr(A_CTL, 0);
    wr(A_EXT, 32'h30);
    wr(A_TC, 0);
    wr(A_CTL, 1);
    wait_edges(5);
    chk("R10 toggle first", 32'(mat_out[0]), 1);
    wait_edges(4);
    chk("R10 toggle second", 32'(mat_out[0]), 0);
    wr(A_CTL, 0);
    wr(A_MCR, 0);
    wr(A_EXT, 0);
  endtask

  task automatic t_pwm;
    wr(A_PWM, 1);
    wr(A_M0, 10);
    wr(A_TC, 5);
    chk("R11 below compare", 32'(mat_out[0]), 0);
    wr(A_TC, 12);
    chk("R11 above compare", 32'(mat_out[0]), 1);
    wr(A_TC, 10);
    chk("R11 at compare", 32'(mat_out[0]), 1);
    wr(A_TC, 9);
    chk("R11 just below", 32'(mat_out[0]), 0);
    wr(A_TC, 12);
    wr(A_PWM, 0);
    chk("R11 off follows state", 32'(mat_out[0]), 0);
  endtask

  task automatic t_readback;
    wr(A_M2, 32'h1111);
    wr(A_M3, 32'h2222);
    wr(A_PR, 32'h0abc);
    wr(A_PWM, 2);
    rd_chk("R12 cmp2", A_M2, 32'h1111);
    rd_chk("R12 cmp3", A_M3, 32'h2222);
    rd_chk("R12 presc", A_PR, 32'h0abc);
    rd_chk("R12 pwm ctl", A_PWM, 2);
    rd_chk("R12 cmp0", A_M0, 10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_prescale;
    t_hold_and_write;
    t_match_reset_int;
    t_match_stop;
    t_capture;
    t_counter;
    t_extmatch;
    t_pwm;
    t_readback;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule